// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads a first-level entry from a page directory and then a second-level entry from a page table, both held in memory. A requester hands over a linear address and a read/write flag while the walker is idle. One cycle-wide response later returns either the physical address or a page fault. A fault tells which level failed and carries the linear address that caused it.

The walker reaches memory through a single request/acknowledge port that reads and writes 32-bit entries. On the way it sets the usage bits in the entries it uses. The accessed flag is set at both levels. The modified flag is set only at the second level, and only for writes. Each update is a read-modify-write, and an entry is written only when one of its bits changes. If the translation-enable input is low when a request is taken, the linear address is returned unchanged and memory is not touched.

Top module: `pt_walker`

## Requirements
- R1: If `xlate_en` is 0 when a request is accepted, the response has no fault, `rsp_phys` equals the linear address, and no memory access is made.
- R2: The first-level entry is read at {`dir_base`[31:12], lin[31:22], 2'b00}. The low 12 bits of `dir_base` are ignored.
- R3: The second-level entry is read at {first-level entry[31:12], lin[21:12], 2'b00}.
- R4: A successful translation returns {second-level entry[31:12], lin[11:0]}.
- R5: If bit 0 (present) of the first-level entry is 0, the response is a fault with `rsp_flt_tbl`=0. No further read and no write is made, and the entry is left unchanged whatever its other bits hold.
- R6: If bit 0 of the second-level entry is 0, the response is a fault with `rsp_flt_tbl`=1, and that entry is not written.
- R7: The walker sets bit 5 (accessed) in a present first-level entry before it reads the second level. It also sets bit 5 in a present second-level entry.
- R8: On a write request, the walker sets bit 6 (modified) in a present second-level entry. Bit 6 of the first-level entry is never changed.
- R9: An entry is written back only when its value changes, and a write-back never clears a bit that was set.
- R10: While `mem_req` is high and `mem_ack` is low, the address, write enable and write data stay stable.
- R11: `req_ready` is high only while idle, with no memory request pending. `rsp_valid` lasts exactly one cycle per accepted request, and `rsp_lin` returns the request's linear address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Translation enable, sampled when a request is accepted |
| dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| req_valid | input | 1 | Request strobe |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ready | output | 1 | Walker is idle and accepts a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_phys | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_flt_tbl | output | 1 | Fault level: 0 first level, 1 second level |
| rsp_lin | output | 32 | Linear address of the answered request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry value |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The walker is tried with many random linear addresses over a memory whose entries have random present, accessed and modified bits. Read and write requests are mixed, and the enable is sometimes low. Comparing the response, both entries afterwards and the count of write cycles tells apart three cases: a correct walk, a skipped write-back, and a spurious write-back. Directed cases cover the rest. A non-present first-level entry with every other bit set shows whether hidden bits are inspected. A write through a first-level entry with bit 6 clear shows whether the modified flag leaks into the first level. Entries with both usage bits already set show whether redundant write cycles are issued. Random wait states on the memory port test the hold-until-acknowledge rule.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int BIT_PRS = 0;
    localparam int BIT_ACC = 5;
    localparam int BIT_MOD = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_DIR_RD, S_DIR_WR, S_TBL_RD, S_TBL_WR, S_RESP
    } walk_st_e;

    typedef struct packed {
        walk_st_e            st;
        logic [ADDR_W-1:0]   lin;
        logic                wr;
        logic [ADDR_W-1:0]   pde;
        logic [ADDR_W-1:0]   pte;
        logic [ADDR_W-1:0]   phys;
        logic                fault;
        logic                flt_tbl;
    } walk_regs_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int ENT_SH = OFF_W - IDX_W;

    always_comb begin
        addr = {base[ADDR_W-1:OFF_W], idx, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/pt_entry_upd.sv
module pt_entry_upd #(
    parameter int ENT_W   = 32,
    parameter int BIT_PRS = 0,
    parameter int BIT_ACC = 5,
    parameter int BIT_MOD = 6
) (
    input  logic [ENT_W-1:0] ent_in,
    input  logic             mark_mod,
    output logic             present,
    output logic [ENT_W-1:0] ent_out,
    output logic             changed
);
    always_comb begin
        present = ent_in[BIT_PRS];
        ent_out = ent_in;
        ent_out[BIT_ACC] = 1'b1;
        if (mark_mod) begin
            ent_out[BIT_MOD] = 1'b1;
        end
        changed = (ent_out != ent_in);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic [31:0]       dir_base,
    input  logic              req_valid,
    input  logic [31:0]       req_lin,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_phys,
    output logic              rsp_fault,
    output logic              rsp_flt_tbl,
    output logic [31:0]       rsp_lin,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int DIR_LO = OFF_W + IDX_W;

    walk_regs_t r_q, r_d;

    logic [ADDR_W-1:0] dir_addr, tbl_addr;
    logic              pde_prs, pde_chg, pte_prs, pte_chg;
    logic [ADDR_W-1:0] pde_new, pte_new;

    pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
        .base (dir_base),
        .idx  (r_q.lin[ADDR_W-1:DIR_LO]),
        .addr (dir_addr)
    );

    pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_addr (
        .base (r_q.pde),
        .idx  (r_q.lin[DIR_LO-1:OFF_W]),
        .addr (tbl_addr)
    );

    pt_entry_upd #(.ENT_W(ADDR_W), .BIT_PRS(BIT_PRS), .BIT_ACC(BIT_ACC), .BIT_MOD(BIT_MOD)) u_pde_upd (
        .ent_in   (mem_rdata),
        .mark_mod (1'b0),
        .present  (pde_prs),
        .ent_out  (pde_new),
        .changed  (pde_chg)
    );

    pt_entry_upd #(.ENT_W(ADDR_W), .BIT_PRS(BIT_PRS), .BIT_ACC(BIT_ACC), .BIT_MOD(BIT_MOD)) u_pte_upd (
        .ent_in   (mem_rdata),
        .mark_mod (r_q.wr),
        .present  (pte_prs),
        .ent_out  (pte_new),
        .changed  (pte_chg)
    );

    always_comb begin
        r_d       = r_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.lin     = req_lin;
                    r_d.wr      = req_write;
                    r_d.fault   = 1'b0;
                    r_d.flt_tbl = 1'b0;
                    r_d.phys    = '0;
                    if (xlate_en) begin
                        r_d.st = S_DIR_RD;
                    end else begin
                        r_d.phys = req_lin;
                        r_d.st   = S_RESP;
                    end
                end
            end
            S_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
                if (mem_ack) begin
                    if (!pde_prs) begin
                        r_d.fault   = 1'b1;
                        r_d.flt_tbl = 1'b0;
                        r_d.st      = S_RESP;
                    end else begin
                        r_d.pde = pde_new;
                        r_d.st  = pde_chg ? S_DIR_WR : S_TBL_RD;
                    end
                end
            end
            S_DIR_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = r_q.pde;
                if (mem_ack) begin
                    r_d.st = S_TBL_RD;
                end
            end
            S_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_ack) begin
                    if (!pte_prs) begin
                        r_d.fault   = 1'b1;
                        r_d.flt_tbl = 1'b1;
                        r_d.st      = S_RESP;
                    end else begin
                        r_d.pte  = pte_new;
                        r_d.phys = {mem_rdata[ADDR_W-1:OFF_W], r_q.lin[OFF_W-1:0]};
                        r_d.st   = pte_chg ? S_TBL_WR : S_RESP;
                    end
                end
            end
            S_TBL_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = r_q.pte;
                if (mem_ack) begin
                    r_d.st = S_RESP;
                end
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                r_d.st    = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_phys    = r_q.phys;
    assign rsp_fault   = r_q.fault;
    assign rsp_flt_tbl = r_q.flt_tbl;
    assign rsp_lin     = r_q.lin;

    // R10: memory request held stable until acknowledged
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11: response strobe lasts one cycle
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: ready only with no memory access in flight
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !rsp_valid);

    // R4: page offset passes through on success
    p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_phys[OFF_W-1:0] == rsp_lin[OFF_W-1:0]);

    // R7: every write-back carries the accessed and present bits
    p_wb_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_ACC] && mem_wdata[BIT_PRS]);

    // R5: fault responses carry no physical address
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_phys == '0);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 4096;
    localparam int N_RAND     = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic [31:0] dir_base = 32'h0000_0ABC;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_flt_tbl;
    logic [31:0] rsp_phys, rsp_lin;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [WORDS];
    int          n_rd, n_wr, wait_cnt;
    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_lin(req_lin), .req_write(req_write),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_phys(rsp_phys),
        .rsp_fault(rsp_fault), .rsp_flt_tbl(rsp_flt_tbl), .rsp_lin(rsp_lin),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: acts between clock edges, random wait states
    always @(negedge clk) begin
        cycles++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                if (mem_addr[31:14] != 0) begin
                    chk(1'b0, "R2/R3 address range", mem_addr, 32'h0000_3FFC);
                end
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[13:2]];
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    n_wr++;
                end else begin
                    n_rd++;
                end
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt--;
            end
        end
    end

    function automatic logic [31:0] rand_pde();
        logic [31:0] v = $urandom;
        v[31:12] = 20'(1 + ($urandom % 3));
        return v;
    endfunction

    task automatic xact(input logic [31:0] lin, input bit wr, input bit en);
        int          di = int'(lin[31:22]);
        logic [31:0] pde = mem[di];
        int          ti = int'(pde[13:12]) * 1024 + int'(lin[21:12]);
        logic [31:0] pte = mem[ti];
        logic [31:0] e_pde = pde, e_pte = pte, e_phys = '0;
        bit          e_flt = 0, e_lvl = 0;
        int          e_rd = 0, e_wr = 0, to = 0;
        if (!en) begin
            e_phys = lin;
        end else if (!pde[0]) begin
            e_flt = 1; e_rd = 1;
        end else begin
            e_pde[5] = 1'b1;
            if (e_pde != pde) e_wr++;
            e_rd = 2;
            if (!pte[0]) begin
                e_flt = 1; e_lvl = 1;
            end else begin
                e_pte[5] = 1'b1;
                if (wr) e_pte[6] = 1'b1;
                if (e_pte != pte) e_wr++;
                e_phys = {pte[31:12], lin[11:0]};
            end
        end
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_write = wr; xlate_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && to < 100) begin
            @(negedge clk);
            to++;
        end
        chk(rsp_valid, "R11 response", {31'b0, rsp_valid}, 32'd1);
        chk(rsp_lin == lin, "R11 rsp_lin", rsp_lin, lin);
        chk(rsp_fault == e_flt, "R5/R6 fault", {31'b0, rsp_fault}, {31'b0, e_flt});
        if (e_flt) chk(rsp_flt_tbl == e_lvl, "R5/R6 level", {31'b0, rsp_flt_tbl}, {31'b0, e_lvl});
        chk(rsp_phys == e_phys, en ? "R2/R3/R4 phys" : "R1 phys", rsp_phys, e_phys);
        chk(mem[di] == e_pde, "R7/R8 dir entry", mem[di], e_pde);
        chk(mem[ti] == e_pte, "R6/R8 table entry", mem[ti], e_pte);
        chk(n_wr == e_wr, "R9 write count", n_wr, e_wr);
        chk(n_rd == e_rd, "R1/R5 read count", n_rd, e_rd);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R11 one-cycle response", {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        wait_cnt = 0;
        for (int i = 0; i < 1024; i++) mem[i] = rand_pde();
        for (int i = 1024; i < WORDS; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R11 reset state",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'd4);
        rst_n = 1'b1;

        // R1: translation disabled
        xact(32'hDEAD_BEEF, 1'b1, 1'b0);
        // R5: non-present first level, other bits all set
        mem[32'h3FF] = 32'hFFFF_FFFE;
        xact(32'hFFC0_1234, 1'b1, 1'b1);
        // R6 + R7: first level gains accessed bit, table entry absent
        mem[2] = 32'h0000_1001;
        mem[1024 + 5] = 32'hFFFF_FFFE;
        xact(32'h0080_5ABC, 1'b0, 1'b1);
        // R8: write sets modified only in table entry
        mem[3] = 32'h0000_2021;
        mem[2048 + 7] = 32'h1234_5001;
        xact(32'h00C0_7FFF, 1'b1, 1'b1);
        // R9: both usage bits already set, no write cycle
        mem[4] = 32'h0000_3061;
        mem[3072 + 9] = 32'hABCD_E061;
        xact(32'h0100_9001, 1'b1, 1'b1);
        xact(32'h0100_9002, 1'b0, 1'b1);

        for (int i = 0; i < N_RAND; i++) begin
            xact($urandom, 1'($urandom), ($urandom % 8) != 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule